// File: doc/BRIEF.md
# Card Clock Divider Generator

This block derives the card-side bus clock of a memory-card host controller from a faster master clock, which may run at up to 100 MHz. A single control word, written through a one-cycle write strobe, holds an 8-bit divider value and five control bits: clock enable, idle power-save, master-clock bypass, and two bus-width selects. The divided output has a period of 2×(N+1) master cycles, where N is the divider value. The longest period is therefore 512 master cycles. When bypass is set, the master clock passes straight through a glitch-free gate.

The generator never produces a runt pulse. A new divider value is taken up only where a high phase ends. Clearing the enable lets the current high phase finish and parks the clock low. The switch between bypass and divided mode happens only while both sources are quiet and low. A registered copy of the bus-width selection is driven to the data-pin logic. A bus-active input lets the power-save option hold the clock low while the bus is idle.

Top module: `card_clk_gen`

## Requirements
- R1: During and after a synchronous active-low reset, `card_clk` is low and `bus_width` reads 2'b00 (1-bit bus).
- R2: The control word has the divider N in bits [7:0], enable in bit 8, power-save in bit 9, bypass in bit 10, 4-bit select in bit 11 and 8-bit select in bit 12. With enable set and bypass clear, every high phase and every low phase of `card_clk` lasts exactly N+1 master cycles.
- R3: With N = 255, the high and low phases each last 256 master cycles, giving a division by 512.
- R4: While enable (bit 8) is clear, `card_clk` stays low. Clearing enable while the clock runs completes the current high phase and then holds the clock low.
- R5: With power-save (bit 9) and enable set, `card_clk` is held low while `bus_active` is low, and it runs at the divided rate while `bus_active` is high.
- R6: With bypass (bit 10) and enable set, `card_clk` is high while the master clock is high and low while it is low, from the third master edge after the write onward.
- R7: `bus_width` takes the value 2'b01 when only bit 11 was written set, 2'b10 when bit 12 was written set (whatever bit 11 is), and 2'b00 when both are clear. It updates on the write edge, and 2'b11 never appears.
- R8: A divider value written while the clock runs is loaded only at the end of a high phase. Every phase seen on `card_clk` is a full N+1 phase of either the old or the new value.
- R9: When the clock starts from the stopped state with a write at master edge E0, the first rising edge of `card_clk` comes at master edge E0+N+2.
- R10: A change between bypass and divided mode takes effect only while the divided output and the bypass gate are both low. The next divided pulses then have full N+1 phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 13 | Control word: divider [7:0], enable, power-save, bypass, 4-bit, 8-bit |
| bus_active | input | 1 | High while a command or data transfer uses the bus |
| card_clk | output | 1 | Generated card clock |
| bus_width | output | 2 | Registered bus width: 00 1-bit, 01 4-bit, 10 8-bit |

## Verification
The bus-width code is due on the write edge itself. The divided clock has two registers on the way from a write: the enable synchroniser, then the divider load. Its first rise is therefore due at edge E0+N+2, and the bench samples the exact cycles E0+N+1 (low) and E0+N+2 (high). Phase widths are measured by counting samples taken 1 ns after each falling master edge, where the divided output is stable. Bypass output is checked 1 ns after both master edges, starting three edges after the write, because the mode flag, the enable synchroniser and the falling-edge gate register each add a stage.

// File: rtl/ccg_pkg.sv
// Package: shared encodings for the card clock generator.
// Assumes the control word places the divider in the low bits and the five
// control bits directly above it, at the offsets listed here.
package ccg_pkg;

    // Bus width code driven to the data-pin logic
    typedef enum logic [1:0] {
        BW_1BIT = 2'b00,
        BW_4BIT = 2'b01,
        BW_8BIT = 2'b10
    } bus_w_e;

    // Control bit offsets, counted from the bit just above the divider field
    localparam int OFS_EN    = 0;
    localparam int OFS_PSAVE = 1;
    localparam int OFS_BYP   = 2;
    localparam int OFS_W4    = 3;
    localparam int OFS_W8    = 4;
    localparam int CTRL_BITS = 5;

endpackage

// File: rtl/ccg_cfg_reg.sv
// Module: control word register.
// Captures the divider and control bits on a write strobe and decodes the
// bus width into a registered code. The 8-bit select wins over the 4-bit one.
// Assumes a single-cycle write strobe in the master clock domain.
module ccg_cfg_reg #(
    parameter  int DIV_W = 8,
    localparam int REG_W = DIV_W + ccg_pkg::CTRL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [DIV_W-1:0] div_val,
    output logic             en,
    output logic             psave,
    output logic             byp,
    output logic [1:0]       bus_width
);
    import ccg_pkg::*;

    bus_w_e width_code;

    // Decode the width selects of the incoming word, 8-bit first
    always_comb begin
        if (wdata[DIV_W + OFS_W8])
            width_code = BW_8BIT;
        else if (wdata[DIV_W + OFS_W4])
            width_code = BW_4BIT;
        else
            width_code = BW_1BIT;
    end

    // Hold the control fields until the next write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val   <= '0;
            en        <= 1'b0;
            psave     <= 1'b0;
            byp       <= 1'b0;
            bus_width <= BW_1BIT;
        end else if (wr_en) begin
            div_val   <= wdata[DIV_W-1:0];
            en        <= wdata[DIV_W + OFS_EN];
            psave     <= wdata[DIV_W + OFS_PSAVE];
            byp       <= wdata[DIV_W + OFS_BYP];
            bus_width <= width_code;
        end
    end

endmodule

// File: rtl/ccg_mode_ctl.sv
// Module: run and mode control.
// Registers the run request, which combines enable with power-save and bus
// activity. It also owns the active mode flag (bypass or divided). The flag
// flips only while the divided output and the bypass gate are both low, so
// the output multiplexer never switches during a pulse. Assumes div_q and
// gate_n come from the divider and the output stage.
module ccg_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic psave,
    input  logic byp,
    input  logic bus_active,
    input  logic div_q,
    input  logic gate_n,
    output logic run_q,
    output logic byp_act,
    output logic run_div,
    output logic gate_req
);
    logic want_run;
    logic mode_ok;

    // Clock is wanted when enabled and not parked by power-save
    assign want_run = en & ~(psave & ~bus_active);
    // Requested mode already in force
    assign mode_ok  = (byp == byp_act);

    // Synchronise the run request into a single register stage
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= want_run;
    end

    // Adopt the requested mode only while both clock sources are quiet
    always_ff @(posedge clk) begin
        if (!rst_n)
            byp_act <= 1'b0;
        else if (!mode_ok && !div_q && !gate_n)
            byp_act <= byp;
    end

    // Route the run request to the source of the active mode
    assign run_div  = run_q & mode_ok & ~byp_act;
    assign gate_req = run_q & mode_ok &  byp_act;

endmodule

// File: rtl/ccg_divider.sv
// Module: divide-by-2(N+1) counter.
// Counts master cycles up to the active limit and toggles the output when
// the limit is reached. The limit reloads from the control word only at the
// end of a high phase or while stopped low. A started high phase always runs
// to completion, even if the run request drops, so no runt pulse appears.
module ccg_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             div_q,
    output logic [DIV_W-1:0] div_act
);
    logic [DIV_W-1:0] cnt;
    logic             at_limit;

    // Terminal count of the current phase
    assign at_limit = (cnt == div_act);

    // Count, toggle at the limit, reload the limit at low-phase boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_q   <= 1'b0;
            div_act <= '0;
        end else if (run || div_q) begin
            if (at_limit) begin
                cnt   <= '0;
                div_q <= ~div_q;
                if (div_q)
                    div_act <= div_cfg;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt     <= '0;
            div_act <= div_cfg;
        end
    end

endmodule

// File: rtl/ccg_out_stage.sv
// Module: output gate and multiplexer.
// A register on the falling master edge holds the bypass gate, so the AND
// with the master clock can only open or close while the clock is low. The
// multiplexer selects the gated master clock or the divided output. Assumes
// the mode flag changes only while both inputs of the multiplexer are low.
module ccg_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    input  logic byp_act,
    input  logic div_q,
    output logic gate_n,
    output logic card_clk
);
    // Update the bypass gate while the master clock is low
    always_ff @(negedge clk) begin
        if (!rst_n)
            gate_n <= 1'b0;
        else
            gate_n <= gate_req;
    end

    // Select the active clock source
    assign card_clk = byp_act ? (clk & gate_n) : div_q;

endmodule

// File: rtl/card_clk_gen.sv
// Module: card clock generator top.
// Joins the control register, run and mode control, divider and output
// stage. Assumes a master clock of at most 100 MHz and that bus_active is
// synchronous to it.
module card_clk_gen #(
    parameter  int DIV_W = 8,
    localparam int REG_W = DIV_W + ccg_pkg::CTRL_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             bus_active,
    output logic             card_clk,
    output logic [1:0]       bus_width
);
    logic [DIV_W-1:0] div_val;
    logic [DIV_W-1:0] div_act;
    logic             cfg_en;
    logic             cfg_psave;
    logic             cfg_byp;
    logic             run_q;
    logic             byp_act;
    logic             run_div;
    logic             gate_req;
    logic             div_q;
    logic             gate_n;

    ccg_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wdata     (reg_wdata),
        .div_val   (div_val),
        .en        (cfg_en),
        .psave     (cfg_psave),
        .byp       (cfg_byp),
        .bus_width (bus_width)
    );

    ccg_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .psave      (cfg_psave),
        .byp        (cfg_byp),
        .bus_active (bus_active),
        .div_q      (div_q),
        .gate_n     (gate_n),
        .run_q      (run_q),
        .byp_act    (byp_act),
        .run_div    (run_div),
        .gate_req   (gate_req)
    );

    ccg_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_div),
        .div_cfg (div_val),
        .div_q   (div_q),
        .div_act (div_act)
    );

    ccg_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_req (gate_req),
        .byp_act  (byp_act),
        .div_q    (div_q),
        .gate_n   (gate_n),
        .card_clk (card_clk)
    );

endmodule

// File: rtl/card_clk_gen_chk.sv
// Module: protocol checker for the card clock generator, bound to the top.
// Observes the divided output, active limit, run register, mode flag and
// bypass gate. A local counter measures high-phase length, so the window
// needs no deep $past.
module card_clk_gen_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_width,
    input logic             div_q,
    input logic [DIV_W-1:0] div_act,
    input logic             run_q,
    input logic             byp_act,
    input logic             gate_n
);
    logic [DIV_W:0] hi_cnt;

    // Length of the current high phase of the divided output
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (div_q)
            hi_cnt <= hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!div_q && !gate_n && bus_width == 2'b00));

    // R2
    hi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_q) |-> (hi_cnt == ({1'b0, $past(div_act)} + {{DIV_W{1'b0}}, 1'b1})));

    // R4
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !div_q) |=> !div_q);

    // R7
    width_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_width != 2'b11);

    // R8
    div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_act) |-> !div_q);

    // R10
    mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byp_act) |-> (!$past(div_q) && !$past(gate_n)));

endmodule

bind card_clk_gen card_clk_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_width (bus_width),
    .div_q     (div_q),
    .div_act   (div_act),
    .run_q     (run_q),
    .byp_act   (byp_act),
    .gate_n    (gate_n)
);

// File: tb/card_clk_gen_bench.sv
module card_clk_gen_bench;
    localparam int DIV_W = 8;
    localparam int REG_W = DIV_W + 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic             bus_active = 1'b0;
    logic             card_clk;
    logic [1:0]       bus_width;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    card_clk_gen #(.DIV_W(DIV_W)) u_card_clk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .bus_active (bus_active),
        .card_clk   (card_clk),
        .bus_width  (bus_width)
    );

    // Control word per R2: divider [7:0], en 8, psave 9, bypass 10, w4 11, w8 12
    function automatic logic [REG_W-1:0] mk_cfg(int n, bit en, bit ps, bit byp, bit w4, bit w8);
        return {w8, w4, byp, ps, en, n[DIV_W-1:0]};
    endfunction

    // Expected phase length per R2
    function automatic int exp_half(int n);
        return n + 1;
    endfunction

    // Expected width code per R7
    function automatic logic [1:0] exp_width(bit w4, bit w8);
        if (w8) return 2'b10;
        if (w4) return 2'b01;
        return 2'b00;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample point: 1 ns after the falling master edge
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Write at the next rising edge (E0); returns in the sample after E0
    task automatic wr(logic [REG_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    // Measure one full high phase and the low phase that follows
    task automatic measure(output int hi, output int lo);
        while (card_clk !== 1'b0) tick();
        while (card_clk !== 1'b1) tick();
        hi = 0;
        while (card_clk === 1'b1) begin hi++; tick(); end
        lo = 0;
        while (card_clk === 1'b0) begin lo++; tick(); end
    endtask

    task automatic stays_low(string req, int n);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            if (card_clk !== 1'b0) highs++;
            tick();
        end
        chk(highs == 0, req, highs, 0);
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int hi, lo, a, b;
        bit ok;
        void'($urandom(32'h5EED));
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk(card_clk === 1'b0, "R1 clk", card_clk, 0);
        chk(bus_width === 2'b00, "R1 width", bus_width, 0);
        rst_n = 1'b1;
        stays_low("R1 idle", 10);

        // R7 width encodings, due on the write edge
        wr(mk_cfg(0, 0, 0, 0, 1, 0));
        chk(bus_width === exp_width(1, 0), "R7 w4", bus_width, exp_width(1, 0));
        wr(mk_cfg(0, 0, 0, 0, 0, 1));
        chk(bus_width === exp_width(0, 1), "R7 w8", bus_width, exp_width(0, 1));
        wr(mk_cfg(0, 0, 0, 0, 1, 1));
        chk(bus_width === exp_width(1, 1), "R7 both", bus_width, exp_width(1, 1));
        wr(mk_cfg(0, 0, 0, 0, 0, 0));
        chk(bus_width === exp_width(0, 0), "R7 none", bus_width, exp_width(0, 0));

        // R4 enable clear: divider set but no clock
        wr(mk_cfg(2, 0, 0, 0, 0, 0));
        stays_low("R4 disabled", 40);

        // R9 first rising edge at E0+N+2
        wr(mk_cfg(4, 1, 0, 0, 0, 0));
        for (int j = 1; j <= 5; j++) tick();
        chk(card_clk === 1'b0, "R9 before", card_clk, 0);
        tick();
        chk(card_clk === 1'b1, "R9 rise", card_clk, 1);
        measure(hi, lo);
        chk(hi == exp_half(4) && lo == exp_half(4), "R2 n4", hi * 1000 + lo, exp_half(4) * 1001);

        // R2 random dividers
        for (int k = 0; k < 10; k++) begin
            a = int'($urandom_range(0, 20));
            wr(mk_cfg(a, 1, 0, 0, 0, 0));
            measure(hi, lo);
            measure(hi, lo);
            chk(hi == exp_half(a) && lo == exp_half(a), "R2 rand", hi * 1000 + lo, exp_half(a) * 1001);
        end

        // R8 divider change while running
        for (int k = 0; k < 4; k++) begin
            a = int'($urandom_range(0, 9));
            b = int'($urandom_range(0, 9));
            wr(mk_cfg(a, 1, 0, 0, 0, 0));
            measure(hi, lo);
            repeat (int'($urandom_range(0, 6))) tick();
            wr(mk_cfg(b, 1, 0, 0, 0, 0));
            ok = 1'b1;
            for (int p = 0; p < 4; p++) begin
                measure(hi, lo);
                if ((hi != exp_half(a) && hi != exp_half(b)) || (lo != exp_half(a) && lo != exp_half(b)))
                    ok = 1'b0;
            end
            chk(ok, "R8 no runt", hi * 1000 + lo, exp_half(b) * 1001);
            chk(hi == exp_half(b) && lo == exp_half(b), "R8 new", hi * 1000 + lo, exp_half(b) * 1001);
        end

        // R4 clear enable while running
        wr(mk_cfg(3, 1, 0, 0, 0, 0));
        measure(hi, lo);
        repeat (2) tick();
        wr(mk_cfg(3, 0, 0, 0, 0, 0));
        repeat (10) tick();
        stays_low("R4 stop", 30);

        // R5 power-save
        bus_active = 1'b0;
        wr(mk_cfg(2, 1, 1, 0, 0, 0));
        repeat (3) tick();
        stays_low("R5 idle", 30);
        bus_active = 1'b1;
        measure(hi, lo);
        chk(hi == exp_half(2) && lo == exp_half(2), "R5 active", hi * 1000 + lo, exp_half(2) * 1001);
        bus_active = 1'b0;
        repeat (8) tick();
        stays_low("R5 idle again", 30);

        // R6 bypass
        wr(mk_cfg(5, 1, 0, 1, 0, 0));
        repeat (3) tick();
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (card_clk !== 1'b1) ok = 1'b0;
            @(negedge clk); #1;
            if (card_clk !== 1'b0) ok = 1'b0;
        end
        chk(ok, "R6 follow", ok, 1);

        // R10 back to divided mode
        wr(mk_cfg(2, 1, 0, 0, 0, 0));
        measure(hi, lo);
        chk(hi == exp_half(2) && lo == exp_half(2), "R10 resume", hi * 1000 + lo, exp_half(2) * 1001);

        // R3 maximum divider
        wr(mk_cfg(255, 1, 0, 0, 0, 0));
        measure(hi, lo);
        measure(hi, lo);
        chk(hi == 256 && lo == 256, "R3 max", hi * 1000 + lo, 256256);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule